// File: doc/BRIEF.md
# Probabilistic Intermittent Fault Injector

This block sits on a data bus inside a circuit under test. It makes one bit of that bus fail now and then, in a way that can be repeated. The bit behaves like a well-behaved intermittent stuck-at fault. Each test application is framed by a start strobe and an end strobe. At every start strobe the block steps a seeded pseudo-random generator and takes the new value as that application's draw. It then compares the draw with a programmable failure probability.

If the draw does not exceed the probability, the selected bus bit is held at the chosen stuck value from the next cycle until the application ends. If the draw is larger, the bus passes through untouched for that application. The fault is always released when the application ends, and the next application gets a fresh draw.

Loading the same seed reproduces the same pattern of faulty and clean applications. This lets a fault campaign be replayed exactly and swept over many probabilities and bit positions.

Top module: `intermit_fault_inj`

## Requirements
- R1: While reset is low and after it is released, faultActive is 0, busOut equals busIn, and the generator holds the fixed substitute value 16'hACE1.
- R2: Each accepted applyStart advances the 16-bit generator by exactly one step. The step shifts the state right by one and XORs in 16'hB400 when the bit shifted out was 1. The new state is that application's draw, and no draw is ever used for two applications.
- R3: The fault activates when the draw, read as an unsigned 16-bit number, is less than or equal to faultProb. faultProb 16'h0000 therefore never activates the fault, and 16'hFFFF always does. faultActive follows in the cycle after the start strobe.
- R4: While the fault is active, busOut bit faultBit is driven to stuckVal and every other bit equals busIn. faultBit and stuckVal are both captured at the start strobe. Later changes to these inputs have no effect on the open application.
- R5: An active fault stays active for the whole application. It clears in the cycle after applyEnd.
- R6: While no fault is active, busOut equals busIn in the same cycle.
- R7: A seedLoad pulse sets the generator state to seedValue. A seedValue of zero is replaced by 16'hACE1.
- R8: Loading the same seed reproduces the same sequence of activations. Two different seeds give different sequences.
- R9: When seedLoad and applyStart are high in the same cycle, the seed is loaded and the start is dropped: no draw is taken and no application opens.
- R10: An applyStart while an application is open takes a fresh draw and restarts the application. An applyStart together with applyEnd opens a new application.
- R11: An applyEnd while no application is open has no effect on the generator, faultActive or busOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| applyStart | input | 1 | One-cycle strobe marking the start of a test application |
| applyEnd | input | 1 | One-cycle strobe marking the end of a test application |
| seedLoad | input | 1 | One-cycle strobe loading seedValue into the generator |
| seedValue | input | RAND_W | Generator seed; zero is replaced by a fixed constant |
| faultProb | input | RAND_W | Failure probability as an unsigned fraction of 2^RAND_W |
| stuckVal | input | 1 | Value forced onto the faulted bit |
| faultBit | input | IDX_W | Index of the bus bit to fault |
| busIn | input | BUS_W | Fault-free bus from the circuit under test |
| busOut | output | BUS_W | Bus with the fault applied when active |
| faultActive | output | 1 | High while the current application carries the fault |

## Verification
The following properties are checked on every cycle:
- busOut never differs from busIn in more than one bit.
- The fault exists only inside an open application.
- The fault state and its captured bit index stay stable between strobes.
- The fault is released after an end strobe.
- The generator never reaches zero.
- A probability of zero never activates the fault, and all ones always does.

Other behaviour can only be shown by the bench scenarios, which drive the block and compare its ports against a model of the generator:
- The exact draw sequence.
- The at-or-below boundary of the comparison.
- Zero-seed substitution.
- Reproducibility across reloaded seeds.
- Dropped or restarting start strobes.
- Ignored stray end strobes.

// File: rtl/intermit_pkg.sv
package intermit_pkg;
  typedef struct packed {
    logic loadSeed;
    logic drawNow;
    logic releaseNow;
  } ctrlStrobes_t;
endpackage

// File: rtl/intermit_ctrl.sv
module intermit_ctrl
  import intermit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         applyStart,
  input  logic         applyEnd,
  input  logic         seedLoad,
  output ctrlStrobes_t strobes,
  output logic         windowOpen
);

  always_comb begin
    strobes.loadSeed   = seedLoad;
    strobes.drawNow    = applyStart && !seedLoad;
    strobes.releaseNow = applyEnd && windowOpen && !strobes.drawNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      windowOpen <= 1'b0;
    end else if (strobes.drawNow) begin
      windowOpen <= 1'b1;
    end else if (strobes.releaseNow) begin
      windowOpen <= 1'b0;
    end
  end

  // R5: an end strobe without a new start closes the window
  assert_end_closes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (applyEnd && !applyStart) |=> !windowOpen);

  // R9: a start that coincides with a seed load opens nothing
  assert_seed_drops_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (seedLoad && applyStart && !windowOpen) |=> !windowOpen);

endmodule

// File: rtl/intermit_datapath.sv
module intermit_datapath
  import intermit_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned RAND_W = 16,
  parameter int unsigned IDX_W  = 3,
  parameter logic [RAND_W-1:0] TAP_MASK      = 16'hB400,
  parameter logic [RAND_W-1:0] ZERO_SEED_SUB = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [RAND_W-1:0] seedValue,
  input  logic [RAND_W-1:0] faultProb,
  input  logic              stuckVal,
  input  logic [IDX_W-1:0]  faultBit,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic              faultActive
);

  logic [RAND_W-1:0] lfsrQ;
  logic [RAND_W-1:0] lfsrNext;
  logic [IDX_W-1:0]  heldBit;
  logic              heldStuck;

  always_comb begin
    lfsrNext = {1'b0, lfsrQ[RAND_W-1:1]} ^ (lfsrQ[0] ? TAP_MASK : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= ZERO_SEED_SUB;
    end else if (strobes.loadSeed) begin
      lfsrQ <= (seedValue == '0) ? ZERO_SEED_SUB : seedValue;
    end else if (strobes.drawNow) begin
      lfsrQ <= lfsrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultActive <= 1'b0;
      heldBit     <= '0;
      heldStuck   <= 1'b0;
    end else if (strobes.drawNow) begin
      faultActive <= (lfsrNext <= faultProb);
      heldBit     <= faultBit;
      heldStuck   <= stuckVal;
    end else if (strobes.releaseNow) begin
      faultActive <= 1'b0;
    end
  end

  for (genvar g = 0; g < BUS_W; g++) begin : gen_force
    assign busOut[g] = (faultActive && (heldBit == IDX_W'(g))) ? heldStuck : busIn[g];
  end

  // R3: zero probability never faults, all-ones always does
  assert_zero_prob_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.drawNow && faultProb == '0) |=> !faultActive);
  assert_full_prob_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.drawNow && faultProb == '1) |=> faultActive);

  // R5: fault held between strobes, dropped on release
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.drawNow && !strobes.releaseNow) |=> $stable(faultActive));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.releaseNow |=> !faultActive);

  // R4: captured bit index does not move inside a window
  assert_bit_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.drawNow |=> $stable(heldBit));

  // R7: generator never locks at zero
  assert_no_lockup_R7: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

endmodule

// File: rtl/intermit_fault_inj.sv
module intermit_fault_inj
  import intermit_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned RAND_W = 16,
  parameter logic [RAND_W-1:0] TAP_MASK      = 16'hB400,
  parameter logic [RAND_W-1:0] ZERO_SEED_SUB = 16'hACE1,
  localparam int unsigned IDX_W = (BUS_W > 1) ? $clog2(BUS_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              applyStart,
  input  logic              applyEnd,
  input  logic              seedLoad,
  input  logic [RAND_W-1:0] seedValue,
  input  logic [RAND_W-1:0] faultProb,
  input  logic              stuckVal,
  input  logic [IDX_W-1:0]  faultBit,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic              faultActive
);

  ctrlStrobes_t strobes;
  logic         windowOpen;

  intermit_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .applyStart (applyStart),
    .applyEnd   (applyEnd),
    .seedLoad   (seedLoad),
    .strobes    (strobes),
    .windowOpen (windowOpen)
  );

  intermit_datapath #(
    .BUS_W         (BUS_W),
    .RAND_W        (RAND_W),
    .IDX_W         (IDX_W),
    .TAP_MASK      (TAP_MASK),
    .ZERO_SEED_SUB (ZERO_SEED_SUB)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .seedValue   (seedValue),
    .faultProb   (faultProb),
    .stuckVal    (stuckVal),
    .faultBit    (faultBit),
    .busIn       (busIn),
    .busOut      (busOut),
    .faultActive (faultActive)
  );

  // R4, R6: at most the one faulted bit differs from the input bus
  assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(busOut ^ busIn) <= 1);

  // R5: a fault only lives inside an open application
  assert_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    faultActive |-> windowOpen);

endmodule

// File: tb/test_intermit_fault_inj.sv
module test_intermit_fault_inj;
  localparam int BUS_W = 8;
  localparam int IDX_W = 3;
  localparam logic [15:0] SUB = 16'hACE1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic applyStart = 0, applyEnd = 0, seedLoad = 0, stuckVal = 0;
  logic [15:0] seedValue = '0, faultProb = '0;
  logic [IDX_W-1:0] faultBit = '0;
  logic [BUS_W-1:0] busIn = '0, busOut;
  logic faultActive;

  int checks = 0, fails = 0;
  logic [15:0] mLfsr;
  logic mAct;
  logic [IDX_W-1:0] mBit;
  logic mStuck;

  always #4 clk = ~clk;

  intermit_fault_inj i_intermit_fault_inj (
    .clk(clk), .rstN(rstN), .applyStart(applyStart), .applyEnd(applyEnd),
    .seedLoad(seedLoad), .seedValue(seedValue), .faultProb(faultProb),
    .stuckVal(stuckVal), .faultBit(faultBit), .busIn(busIn),
    .busOut(busOut), .faultActive(faultActive));

  function automatic logic [15:0] stepLfsr(logic [15:0] s);
    return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0);
  endfunction

  function automatic logic [BUS_W-1:0] expBus(logic [BUS_W-1:0] b, logic a,
                                              logic [IDX_W-1:0] i, logic v);
    logic [BUS_W-1:0] r = b;
    if (a) r[i] = v;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkPorts(string req);
    logic [BUS_W-1:0] e = expBus(busIn, mAct, mBit, mStuck);
    check(faultActive === mAct, {req, " active"}, 32'(faultActive), 32'(mAct));
    check(busOut === e, {req, " bus"}, 32'(busOut), 32'(e));
  endtask

  task automatic doStart(logic [15:0] p, logic [IDX_W-1:0] b, logic v, logic withEnd);
    @(negedge clk);
    faultProb = p; faultBit = b; stuckVal = v; applyStart = 1; applyEnd = withEnd;
    mLfsr = stepLfsr(mLfsr);
    mAct = (mLfsr <= p); mBit = b; mStuck = v;
    @(negedge clk);
    applyStart = 0; applyEnd = 0;
  endtask

  task automatic doEnd();
    @(negedge clk); applyEnd = 1;
    @(negedge clk); applyEnd = 0;
    mAct = 0;
  endtask

  task automatic doSeed(logic [15:0] s);
    @(negedge clk); seedLoad = 1; seedValue = s;
    @(negedge clk); seedLoad = 0;
    mLfsr = (s == 0) ? SUB : s;
  endtask

  task automatic pattern(int n, output logic [31:0] pat);
    pat = '0;
    for (int k = 0; k < n; k++) begin
      doStart(16'h8000, 3'd0, 1'b0, 1'b0);
      pat[k] = faultActive;
      doEnd();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] pA, pB, pA2, mA, mB;
    logic [15:0] d;
    int unused;
    unused = $urandom(32'd2024);
    mLfsr = SUB; mAct = 0; mBit = 0; mStuck = 0;
    busIn = 8'h5A;
    repeat (3) @(negedge clk);
    checkPorts("R1 in reset");
    rstN = 1;
    @(negedge clk);
    checkPorts("R1 after reset");

    // R1/R2: first draw from the reset constant, exact boundary (R3)
    d = stepLfsr(SUB);
    doStart(d, 3'd2, 1'b0, 1'b0);
    checkPorts("R3 draw equal to threshold hits");
    busIn = 8'hFF; #1;
    checkPorts("R4 stuck-at-0 on held bit");
    faultBit = 3'd5; stuckVal = 1'b1; @(negedge clk);
    checkPorts("R4 mid-window input changes ignored");
    repeat (3) @(negedge clk);
    checkPorts("R5 held for whole window");
    doEnd();
    checkPorts("R5 cleared after end");
    busIn = 8'h00; #1;
    checkPorts("R6 passthrough inactive");

    // R3: draw one above threshold misses
    d = stepLfsr(mLfsr);
    doStart(d - 16'd1, 3'd1, 1'b1, 1'b0);
    checkPorts("R3 draw above threshold misses");
    doEnd();

    // R3: zero and all-ones probability
    doStart(16'h0000, 3'd3, 1'b1, 1'b0);
    checkPorts("R3 zero probability");
    doEnd();
    doStart(16'hFFFF, 3'd7, 1'b1, 1'b0);
    checkPorts("R3 full probability");
    doEnd();

    // R7: zero seed replaced
    doSeed(16'h0000);
    d = stepLfsr(SUB);
    doStart(d, 3'd0, 1'b1, 1'b0);
    checkPorts("R7 zero seed hit at boundary");
    doEnd();
    doSeed(16'h0000);
    doStart(d - 16'd1, 3'd0, 1'b1, 1'b0);
    checkPorts("R7 zero seed miss below boundary");
    doEnd();

    // R8: reproducibility and seed sensitivity
    doSeed(16'h1234); mA = '0;
    for (int k = 0; k < 32; k++) begin mLfsr = stepLfsr(mLfsr); mA[k] = (mLfsr <= 16'h8000); end
    doSeed(16'h1234); pattern(32, pA);
    check(pA === mA, "R8 seed sequence matches model", pA, mA);
    doSeed(16'h1234); pattern(32, pA2);
    check(pA2 === pA, "R8 same seed same sequence", pA2, pA);
    doSeed(16'h4321); mB = '0;
    for (int k = 0; k < 32; k++) begin mLfsr = stepLfsr(mLfsr); mB[k] = (mLfsr <= 16'h8000); end
    doSeed(16'h4321); pattern(32, pB);
    check(pB === mB, "R8 second seed matches model", pB, mB);
    check(pB !== pA, "R8 different seeds differ", pB, pA);

    // R9: seed load and start together
    @(negedge clk);
    seedLoad = 1; seedValue = 16'h0BEE; applyStart = 1; faultProb = 16'hFFFF;
    @(negedge clk);
    seedLoad = 0; applyStart = 0; mLfsr = 16'h0BEE; mAct = 0;
    checkPorts("R9 start dropped");
    d = stepLfsr(16'h0BEE);
    doStart(d, 3'd4, 1'b1, 1'b0);
    checkPorts("R9 seed was loaded");
    doEnd();

    // R10: restart inside window, start with end
    doStart(16'hFFFF, 3'd1, 1'b1, 1'b0);
    checkPorts("R10 first window");
    doStart(16'h0000, 3'd1, 1'b1, 1'b0);
    checkPorts("R10 restart redraws");
    doStart(16'hFFFF, 3'd6, 1'b0, 1'b1);
    busIn = 8'hFF; #1;
    checkPorts("R10 start with end opens");
    doEnd();

    // R11: stray end ignored
    doEnd();
    checkPorts("R11 stray end");
    d = stepLfsr(mLfsr);
    doStart(d, 3'd2, 1'b0, 1'b0);
    checkPorts("R11 generator untouched by stray end");
    doEnd();

    // Random windows (R2..R6)
    for (int n = 0; n < 300; n++) begin
      logic [15:0] p;
      int sel = $urandom_range(0, 9);
      p = (sel == 0) ? 16'h0000 : (sel == 1) ? 16'hFFFF : 16'($urandom());
      busIn = 8'($urandom());
      doStart(p, 3'($urandom()), 1'($urandom()), 1'b0);
      checkPorts("R2 random draw");
      for (int c = 0; c < 3; c++) begin
        busIn = 8'($urandom()); faultBit = 3'($urandom()); stuckVal = 1'($urandom());
        @(negedge clk);
        checkPorts("R4 random window");
      end
      doEnd();
      checkPorts("R5 random release");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule